// File: doc/BRIEF.md
# Interrupt Status and Enable Unit

This block collects event pulses from a serial bus controller into a 16-bit sticky status register. It pairs that register with a 16-bit enable register and drives one level interrupt line. Software reaches both registers over a simple single-cycle register bus. It acknowledges events by writing ones into the status register. Each 1 clears the matching bit and each 0 leaves its bit alone, so any group of events can be acknowledged in one write.

Bit 12 of the status register is not sticky. It shows the live bus-busy input and cannot be cleared. Status bits 14 and 13 flag the transmit and receive FIFO drain events. Bits 4 and 3 flag transmit ready and receive ready. Together these four are the data-ready bits, and they are acknowledged on their own, apart from the error bits. The interrupt output is registered. It is produced by a two-state machine. In `IRQ_QUIET` the line is low. The transition `quiet_to_raised` fires when any status bit is set together with its enable bit, and it moves the machine to `IRQ_RAISED`. The transition `raised_to_quiet` fires when no such pair remains.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, the sticky status bits, the enable register, `irq_o` and `bus_rdata` are all 0.
- R2: The enable register sits at offset 0x04. It stores only bits 14, 13, 4, 3, 2 and 1 and 0. Writes to the other bit positions are dropped, and those positions read 0.
- R3: A 1 on `evt_set[i]` at a clock edge sets status bit i. The sticky positions are 14, 13, 11, 10, 9, 8, 4, 3, 2, 1 and 0. The bit stays set until software clears it.
- R4: A write to offset 0x08 clears every status bit whose `bus_wdata` bit is 1 and leaves every bit written 0 unchanged.
- R5: When a set event and a write-1 clear reach the same status bit at the same edge, the bit ends up set.
- R6: Status bit 12 always reads the current level of `bus_busy_i`. Writes to bit 12 have no effect, and so does `evt_set[12]`.
- R7: Status bit positions 15, 7, 6 and 5 always read 0, and events on those positions are ignored.
- R8: `irq_o` goes high one cycle after status AND enable first becomes nonzero. It goes low one cycle after that AND becomes zero.
- R9: A write that clears only error bits (11, 10, 9, 8, 1, 0) leaves the data-ready bits (14, 13, 4, 3) set.
- R10: A read returns its data on `bus_rdata` in the cycle after the read strobe. Offsets other than 0x04 and 0x08 read 0, and `bus_rdata` is 0 in any cycle that does not follow a read.
- R11: A write to any offset other than 0x04 and 0x08 changes neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read strobe |
| evt_set | input | 16 | Event pulses, one per status bit position |
| bus_busy_i | input | 1 | Live bus-busy level |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The assertions take for granted that each bus access lasts exactly one strobed cycle and that the event inputs are clean synchronous pulses. They also assume the busy input is synchronous to `clk`. The stimulus drives every input on the falling edge, one strobe per access, and holds each event for one clock. Cases where an event and a clear coincide are created on purpose, so that the priority properties are exercised.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int REG_W = 16;

    // Status bit positions (shared with the enable register where present)
    localparam int B_TX_DRAIN = 14;
    localparam int B_RX_DRAIN = 13;
    localparam int B_BUSY     = 12;
    localparam int B_RX_OVR   = 11;
    localparam int B_TX_UNDER = 10;
    localparam int B_SLV_ADDR = 9;
    localparam int B_GC_ZERO  = 8;
    localparam int B_TX_READY = 4;
    localparam int B_RX_READY = 3;
    localparam int B_ACC_RDY  = 2;
    localparam int B_NO_ACK   = 1;
    localparam int B_ARB_LOST = 0;

    localparam logic [REG_W-1:0] READY_MASK =
        (REG_W'(1) << B_TX_DRAIN) | (REG_W'(1) << B_RX_DRAIN) |
        (REG_W'(1) << B_TX_READY) | (REG_W'(1) << B_RX_READY);

    localparam logic [REG_W-1:0] ERROR_MASK =
        (REG_W'(1) << B_RX_OVR)   | (REG_W'(1) << B_TX_UNDER) |
        (REG_W'(1) << B_SLV_ADDR) | (REG_W'(1) << B_GC_ZERO)  |
        (REG_W'(1) << B_NO_ACK)   | (REG_W'(1) << B_ARB_LOST);

    localparam logic [REG_W-1:0] STICKY_MASK = READY_MASK | ERROR_MASK |
        (REG_W'(1) << B_ACC_RDY);

    localparam logic [REG_W-1:0] ENABLE_MASK = READY_MASK |
        (REG_W'(1) << B_ACC_RDY) | (REG_W'(1) << B_NO_ACK) |
        (REG_W'(1) << B_ARB_LOST);

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    typedef struct packed {
        logic en_wr;
        logic st_wr;
        logic en_rd;
        logic st_rd;
        logic any_rd;
    } acc_dec_t;

endpackage

// File: rtl/evt_irq_decode.sv
module evt_irq_decode
    import evt_irq_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter logic [7:0]  OFS_EN  = 8'h04,
    parameter logic [7:0]  OFS_ST  = 8'h08
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output acc_dec_t          dec
);
    localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(OFS_EN);
    localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(OFS_ST);

    logic hit_en;
    logic hit_st;

    always_comb begin
        hit_en     = (addr == A_EN);
        hit_st     = (addr == A_ST);
        dec.en_wr  = sel &  wr & hit_en;
        dec.st_wr  = sel &  wr & hit_st;
        dec.en_rd  = sel & ~wr & hit_en;
        dec.st_rd  = sel & ~wr & hit_st;
        dec.any_rd = sel & ~wr;
    end

endmodule

// File: rtl/evt_irq_status.sv
module evt_irq_status
    import evt_irq_pkg::*;
#(
    parameter int               W       = REG_W,
    parameter logic [W-1:0]     STICKY  = STICKY_MASK,
    parameter int               BUSY_AT = B_BUSY
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_en_i,
    input  logic [W-1:0] clr_bits_i,
    input  logic         busy_i,
    output logic [W-1:0] sticky_o,
    output logic [W-1:0] view_o
);
    logic [W-1:0] q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (STICKY[i]) begin : g_sticky
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q[i] <= 1'b0;
                else if (set_i[i])
                    q[i] <= 1'b1;
                else if (clr_en_i && clr_bits_i[i])
                    q[i] <= 1'b0;
            end

            // R3 R5
            set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                set_i[i] |=> q[i]);
            // R4
            w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_en_i && clr_bits_i[i] && !set_i[i]) |=> !q[i]);
            // R4 R9
            hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!set_i[i] && !(clr_en_i && clr_bits_i[i])) |=> $stable(q[i]));
        end else begin : g_fixed
            assign q[i] = 1'b0;
        end
    end

    always_comb begin
        sticky_o = q;
        view_o   = q;
        view_o[BUSY_AT] = busy_i;
    end

endmodule

// File: rtl/evt_irq_fsm.sv
module evt_irq_fsm
    import evt_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    output logic irq_o
);
    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= IRQ_QUIET;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pending_i)  state_d = IRQ_RAISED;   // quiet_to_raised
            IRQ_RAISED: if (!pending_i) state_d = IRQ_QUIET;    // raised_to_quiet
            default:                    state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end

    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending_i |=> irq_o);
    // R8
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pending_i |=> !irq_o);

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int         ADDR_W = 8,
    parameter int         W      = REG_W,
    parameter logic [7:0] OFS_EN = 8'h04,
    parameter logic [7:0] OFS_ST = 8'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      evt_set,
    input  logic              bus_busy_i,
    output logic              irq_o
);
    localparam logic [W-1:0] EN_KEEP = W'(ENABLE_MASK);

    acc_dec_t     dec;
    logic [W-1:0] en_q;
    logic [W-1:0] sticky;
    logic [W-1:0] view;
    logic [W-1:0] rd_mux;
    logic [W-1:0] rdata_q;
    logic         pending;

    evt_irq_decode #(
        .ADDR_W (ADDR_W),
        .OFS_EN (OFS_EN),
        .OFS_ST (OFS_ST)
    ) u_dec (
        .sel  (bus_sel),
        .wr   (bus_wr),
        .addr (bus_addr),
        .dec  (dec)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en_q <= '0;
        else if (dec.en_wr)
            en_q <= bus_wdata & EN_KEEP;
    end

    evt_irq_status #(
        .W       (W),
        .STICKY  (W'(STICKY_MASK)),
        .BUSY_AT (B_BUSY)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (evt_set),
        .clr_en_i   (dec.st_wr),
        .clr_bits_i (bus_wdata),
        .busy_i     (bus_busy_i),
        .sticky_o   (sticky),
        .view_o     (view)
    );

    always_comb begin
        pending = |(sticky & en_q);
    end

    evt_irq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (pending),
        .irq_o     (irq_o)
    );

    always_comb begin
        rd_mux = '0;
        if (dec.en_rd)
            rd_mux = en_q;
        else if (dec.st_rd)
            rd_mux = view;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (dec.any_rd)
            rdata_q <= rd_mux;
        else
            rdata_q <= '0;
    end

    assign bus_rdata = rdata_q;

    // R2
    enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec.en_wr |=> (en_q == ($past(bus_wdata) & EN_KEEP)));
    // R11
    enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec.en_wr |=> $stable(en_q));
    // R10
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> (bus_rdata == '0));
    // R10
    rdata_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !dec.en_rd && !dec.st_rd) |=> (bus_rdata == '0));

endmodule

// File: tb/evt_irq_ctrl_test.sv
`timescale 1ns/1ps
module evt_irq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] evt_set = '0;
    logic        bus_busy_i = 1'b0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    evt_irq_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .evt_set    (evt_set),
        .bus_busy_i (bus_busy_i),
        .irq_o      (irq_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] bits);
        @(negedge clk);
        evt_set = bits;
        @(negedge clk);
        evt_set = '0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 irq", {15'd0, irq_o}, 16'h0);
        check("R1 rdata", bus_rdata, 16'h0);
        reg_read(8'h08, v); check("R1 status", v, 16'h0);
        reg_read(8'h04, v); check("R1 enable", v, 16'h0);
    endtask

    task automatic t_enable();
        logic [15:0] v;
        reg_write(8'h04, 16'hFFFF);
        reg_read(8'h04, v); check("R2 enable mask", v, 16'h601F);
        reg_write(8'h04, 16'h0005);
        reg_read(8'h04, v); check("R2 enable value", v, 16'h0005);
        reg_write(8'h04, 16'h0000);
    endtask

    task automatic t_events();
        logic [15:0] v;
        pulse(16'hFFFF);
        reg_read(8'h08, v); check("R3 R7 R6 all events", v, 16'h6F1F);
        repeat (3) @(negedge clk);
        reg_read(8'h08, v); check("R3 sticky hold", v, 16'h6F1F);
        check("R8 no irq when disabled", {15'd0, irq_o}, 16'h0);
    endtask

    task automatic t_w1c();
        logic [15:0] v;
        reg_write(8'h08, 16'h0F03);
        reg_read(8'h08, v); check("R9 R4 errors cleared ready kept", v, 16'h601C);
        reg_write(8'h08, 16'h0000);
        reg_read(8'h08, v); check("R4 zero write no change", v, 16'h601C);
        reg_write(8'h08, 16'h2008);
        reg_read(8'h08, v); check("R4 partial clear", v, 16'h4014);
        reg_write(8'h08, 16'hFFFF);
        reg_read(8'h08, v); check("R4 clear all", v, 16'h0000);
    endtask

    task automatic t_busy();
        logic [15:0] v;
        @(negedge clk); bus_busy_i = 1'b1;
        reg_read(8'h08, v); check("R6 busy live", v, 16'h1000);
        reg_write(8'h08, 16'h1000);
        reg_read(8'h08, v); check("R6 busy write ignored", v, 16'h1000);
        @(negedge clk); bus_busy_i = 1'b0;
        reg_read(8'h08, v); check("R6 busy drops", v, 16'h0000);
    endtask

    task automatic t_irq();
        reg_write(8'h04, 16'h0008);
        pulse(16'h0008);
        check("R8 irq not yet", {15'd0, irq_o}, 16'h0);
        @(negedge clk);
        check("R8 irq raised", {15'd0, irq_o}, 16'h1);
        reg_write(8'h08, 16'h0008);
        check("R8 irq still high", {15'd0, irq_o}, 16'h1);
        @(negedge clk);
        check("R8 irq dropped", {15'd0, irq_o}, 16'h0);
        pulse(16'h0800);
        repeat (2) @(negedge clk);
        check("R8 masked event", {15'd0, irq_o}, 16'h0);
        reg_write(8'h08, 16'h0800);
        reg_write(8'h04, 16'h0000);
    endtask

    task automatic t_collide();
        logic [15:0] v;
        @(negedge clk);
        evt_set = 16'h0002;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 16'h0002;
        @(negedge clk);
        evt_set = '0; bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        reg_read(8'h08, v); check("R5 set wins", v, 16'h0002);
        reg_write(8'h08, 16'h0002);
        reg_read(8'h08, v); check("R5 later clear", v, 16'h0000);
    endtask

    task automatic t_other();
        logic [15:0] v;
        reg_write(8'h04, 16'h0003);
        pulse(16'h0010);
        reg_write(8'h0C, 16'hFFFF);
        reg_write(8'h00, 16'hFFFF);
        reg_read(8'h04, v); check("R11 enable untouched", v, 16'h0003);
        reg_read(8'h08, v); check("R11 status untouched", v, 16'h0010);
        reg_read(8'h0C, v); check("R10 other offset reads 0", v, 16'h0000);
        @(negedge clk);
        check("R10 idle rdata", bus_rdata, 16'h0000);
        pulse(16'h00E0 | 16'h8000);
        reg_read(8'h08, v); check("R7 unused ignored", v, 16'h0010);
        reg_write(8'h08, 16'hFFFF);
        reg_write(8'h04, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_events();
        t_w1c();
        t_busy();
        t_irq();
        t_collide();
        t_other();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule